// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a byte-wide parallel flash and watches the stream of write cycles. Each write is presented for one clock as an address and data pair. The block recognises the command sequences that begin with an unlock prefix. When a sequence completes, it pulses a one-clock request to the embedded-operation engine. The requests cover byte program (with target address and data), whole-array erase, erase of one 4 KB page (with page number), lock of the top or bottom 16 KB boot block, and entry to or exit from identification mode. A registered flag shows whether reads are in normal array mode or identification mode.

Every sequence starts with AA written to command address 5555, then 55 written to 2AAA. The third write picks the branch. A0 leads to byte program, where the fourth write is the program target. 80 opens the erase/lock branch, which repeats the two unlock writes and then takes a final code. 90 enters identification mode. F0 leaves identification mode. A single F0 written at any address while no sequence is open also leaves it. Writes offered while the `busy` input is high are discarded.

Top module: `flash_cmd_decoder`

States, all named in the package:
- `ST_IDLE`: waiting for a sequence.
- `ST_UNL1`: AA@5555 has been seen.
- `ST_UNL2`: 55@2AAA has been seen.
- `ST_PROG`: A0 has been seen; the next write is the program target.
- `ST_ERS1`: 80 has been seen.
- `ST_ERS2`: the second AA has been seen.
- `ST_ERS3`: the second 55 has been seen.
- `ST_LOCK`: 70 has been seen; the next write picks the boot block.

Transitions:
- Every accepted write that matches the expected pattern moves the machine one state forward.
- Any completion returns the machine to `ST_IDLE`.
- Any mismatch returns the machine to `ST_IDLE` and is an abort.

## Requirements
- R1: After reset, all request outputs are 0, `id_mode` is 0, and no sequence is open.
- R2: The writes AA@5555, 55@2AAA, A0@5555 followed by a write (A, D) raise `prog_req` for the one clock after the fourth write, with `prog_addr`=A and `prog_data`=D.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 raise `chip_erase_req` for the one clock after the sixth write.
- R4: The same five-write prefix followed by data 50 at any address raises `page_erase_req` for one clock, with `page_num` equal to address bits 16..12 of that write.
- R5: The same five-write prefix followed by 70@5555 arms a lock. The next write at address 1FFFF raises `lock_top_req`, and the next write at 00000 raises `lock_bot_req`. The data of that write is ignored. Any other address aborts.
- R6: AA@5555, 55@2AAA, 90@5555 raises `id_enter_req` for one clock, and `id_mode` reads 1 from that clock on.
- R7: AA@5555, 55@2AAA, F0@5555 raises `id_exit_req` and clears `id_mode`. So does a single write of data F0 at any address while no sequence is open.
- R8: A write with an unexpected address or data closes the open sequence, clears `id_mode`, and raises no request. That write is not taken as the first write of a new sequence.
- R9: Writes offered while `busy` is 1 change neither the sequence state nor `id_mode`, and raise no request. One clock after any cycle with `busy` high, all requests are 0.
- R10: At most one request output is high in any clock. `prog_req`, erase requests and lock requests never stay high for two clocks in a row.
- R11: Command address compares use only address bits 14..0. Bits 16 and 15 of a command write are don't-care.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One write cycle is presented this clock |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation running; writes are ignored |
| prog_req | output | 1 | Byte program request pulse |
| prog_addr | output | 17 | Program target address |
| prog_data | output | 8 | Program data |
| chip_erase_req | output | 1 | Whole-array erase request pulse |
| page_erase_req | output | 1 | Page erase request pulse |
| page_num | output | 5 | Page selected for erase |
| lock_top_req | output | 1 | Top boot-block lock request pulse |
| lock_bot_req | output | 1 | Bottom boot-block lock request pulse |
| id_enter_req | output | 1 | Identification entry pulse |
| id_exit_req | output | 1 | Identification exit pulse |
| id_mode | output | 1 | 1 while in identification mode |

## Verification
The bound checker watches some properties on every clock:
- the requests stay mutually exclusive and single-clock;
- nothing is requested and `id_mode` holds one clock after a busy cycle;
- `id_mode` agrees with the entry and exit pulses;
- a program request is always preceded by an accepted write.

Other behaviour only the bench scenarios can show:
- that each exact sequence, including the don't-care upper address bits, completes with the right payload;
- that an aborting write does not restart a sequence;
- that a busy write in mid-sequence leaves the sequence open to continue afterwards.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_LOCK
    } fcd_state_t;

    localparam int CMP_W = 15;
    localparam logic [CMP_W-1:0] ADDR_KEY1 = 15'h5555;
    localparam logic [CMP_W-1:0] ADDR_KEY2 = 15'h2AAA;

    localparam logic [7:0] D_KEY1  = 8'hAA;
    localparam logic [7:0] D_KEY2  = 8'h55;
    localparam logic [7:0] D_PROG  = 8'hA0;
    localparam logic [7:0] D_ERASE = 8'h80;
    localparam logic [7:0] D_IDIN  = 8'h90;
    localparam logic [7:0] D_IDOUT = 8'hF0;
    localparam logic [7:0] D_CHIP  = 8'h10;
    localparam logic [7:0] D_PAGE  = 8'h50;
    localparam logic [7:0] D_LOCK  = 8'h70;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              at_key1,
    output logic              at_key2,
    output logic              at_top,
    output logic              at_bot
);
    // R11: only the low CMP_W address bits take part in command compares
    assign at_key1 = (addr[CMP_W-1:0] == ADDR_KEY1);
    assign at_key2 = (addr[CMP_W-1:0] == ADDR_KEY2);
    assign at_top  = (addr == {ADDR_W{1'b1}});
    assign at_bot  = (addr == {ADDR_W{1'b0}});
endmodule

// File: rtl/fcd_id_mode.sv
module fcd_id_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic mode_o
);
    // R6 / R7 / R8: entry sets, exit or abort clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_o <= 1'b0;
        else if (set_i)
            mode_o <= 1'b1;
        else if (clr_i)
            mode_o <= 1'b0;
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int PAGE_LSB = 12,
    localparam int PAGE_W  = ADDR_W - PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              chip_erase_req,
    output logic              page_erase_req,
    output logic [PAGE_W-1:0] page_num,
    output logic              lock_top_req,
    output logic              lock_bot_req,
    output logic              id_enter_req,
    output logic              id_exit_req,
    output logic              id_mode
);
    fcd_state_t st, st_nxt;

    logic acc;
    logic at_key1, at_key2, at_top, at_bot;
    logic ev_prog, ev_chip, ev_page, ev_ltop, ev_lbot, ev_enter, ev_exit, ev_abort;

    // R9: a write counts only while the engine is idle
    assign acc = wr_valid && !busy;

    fcd_match #(.ADDR_W(ADDR_W)) i_match (
        .addr    (wr_addr),
        .at_key1 (at_key1),
        .at_key2 (at_key2),
        .at_top  (at_top),
        .at_bot  (at_bot)
    );

    always_comb begin
        st_nxt   = st;
        ev_prog  = 1'b0;
        ev_chip  = 1'b0;
        ev_page  = 1'b0;
        ev_ltop  = 1'b0;
        ev_lbot  = 1'b0;
        ev_enter = 1'b0;
        ev_exit  = 1'b0;
        ev_abort = 1'b0;
        if (acc) begin
            unique case (st)
                ST_IDLE: begin
                    if (wr_data == D_IDOUT)
                        ev_exit = 1'b1;
                    else if (at_key1 && wr_data == D_KEY1)
                        st_nxt = ST_UNL1;
                    else
                        ev_abort = 1'b1;
                end
                ST_UNL1, ST_ERS2: begin
                    if (at_key2 && wr_data == D_KEY2) begin
                        st_nxt = (st == ST_UNL1) ? ST_UNL2 : ST_ERS3;
                    end else begin
                        st_nxt   = ST_IDLE;
                        ev_abort = 1'b1;
                    end
                end
                ST_UNL2: begin
                    st_nxt = ST_IDLE;
                    if (!at_key1)
                        ev_abort = 1'b1;
                    else begin
                        case (wr_data)
                            D_PROG:  st_nxt   = ST_PROG;
                            D_ERASE: st_nxt   = ST_ERS1;
                            D_IDIN:  ev_enter = 1'b1;
                            D_IDOUT: ev_exit  = 1'b1;
                            default: ev_abort = 1'b1;
                        endcase
                    end
                end
                ST_PROG: begin
                    st_nxt  = ST_IDLE;
                    ev_prog = 1'b1;
                end
                ST_ERS1: begin
                    if (at_key1 && wr_data == D_KEY1)
                        st_nxt = ST_ERS2;
                    else begin
                        st_nxt   = ST_IDLE;
                        ev_abort = 1'b1;
                    end
                end
                ST_ERS3: begin
                    st_nxt = ST_IDLE;
                    if (at_key1 && wr_data == D_CHIP)
                        ev_chip = 1'b1;
                    else if (wr_data == D_PAGE)
                        ev_page = 1'b1;
                    else if (at_key1 && wr_data == D_LOCK)
                        st_nxt = ST_LOCK;
                    else
                        ev_abort = 1'b1;
                end
                ST_LOCK: begin
                    st_nxt = ST_IDLE;
                    if (at_top)
                        ev_ltop = 1'b1;
                    else if (at_bot)
                        ev_lbot = 1'b1;
                    else
                        ev_abort = 1'b1;
                end
            endcase
        end
    end

    // state register (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // request and payload register (R2..R7, R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_req       <= 1'b0;
            chip_erase_req <= 1'b0;
            page_erase_req <= 1'b0;
            lock_top_req   <= 1'b0;
            lock_bot_req   <= 1'b0;
            id_enter_req   <= 1'b0;
            id_exit_req    <= 1'b0;
            prog_addr      <= '0;
            prog_data      <= '0;
            page_num       <= '0;
        end else begin
            prog_req       <= ev_prog;
            chip_erase_req <= ev_chip;
            page_erase_req <= ev_page;
            lock_top_req   <= ev_ltop;
            lock_bot_req   <= ev_lbot;
            id_enter_req   <= ev_enter;
            id_exit_req    <= ev_exit;
            if (ev_prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (ev_page)
                page_num <= wr_addr[ADDR_W-1:PAGE_LSB];
        end
    end

    fcd_id_mode i_idm (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_enter),
        .clr_i  (ev_exit || ev_abort),
        .mode_o (id_mode)
    );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic busy,
    input logic prog_req,
    input logic chip_erase_req,
    input logic page_erase_req,
    input logic lock_top_req,
    input logic lock_bot_req,
    input logic id_enter_req,
    input logic id_exit_req,
    input logic id_mode
);
    logic [6:0] reqs;
    assign reqs = {prog_req, chip_erase_req, page_erase_req, lock_top_req,
                   lock_bot_req, id_enter_req, id_exit_req};

    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));

    // R10
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R10
    erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_erase_req || page_erase_req || lock_top_req || lock_bot_req)
        |=> !(chip_erase_req || page_erase_req || lock_top_req || lock_bot_req));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (reqs == 7'd0));

    // R9
    busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(id_mode));

    // R6
    enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_enter_req |-> id_mode);

    // R7
    exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_exit_req |-> !id_mode);

    // R2
    prog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wr_valid && !busy));
endmodule

bind flash_cmd_decoder fcd_checker i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .busy           (busy),
    .prog_req       (prog_req),
    .chip_erase_req (chip_erase_req),
    .page_erase_req (page_erase_req),
    .lock_top_req   (lock_top_req),
    .lock_bot_req   (lock_bot_req),
    .id_enter_req   (id_enter_req),
    .id_exit_req    (id_exit_req),
    .id_mode        (id_mode)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        prog_req, chip_erase_req, page_erase_req;
    logic        lock_top_req, lock_bot_req, id_enter_req, id_exit_req, id_mode;
    logic [16:0] prog_addr;
    logic [7:0]  prog_data;
    logic [4:0]  page_num;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .chip_erase_req(chip_erase_req), .page_erase_req(page_erase_req),
        .page_num(page_num), .lock_top_req(lock_top_req),
        .lock_bot_req(lock_bot_req), .id_enter_req(id_enter_req),
        .id_exit_req(id_exit_req), .id_mode(id_mode)
    );

    // behavioural reference: queue of accepted writes in the open sequence
    int qa[$];
    int qd[$];
    bit e_prog, e_chip, e_page, e_top, e_bot, e_in, e_out, e_id;
    int e_paddr, e_pdata, e_page_n;

    function automatic bit hit(int a, int d, int ea, int ed);
        return ((a & 32'h7FFF) == ea) && (d == ed);
    endfunction

    // result: 0 open, 1 invalid, 2 prog, 3 chip, 4 page, 5 top, 6 bot, 7 enter, 8 exit
    function automatic int classify();
        int n = qa.size();
        int a = qa[n-1];
        int d = qd[n-1];
        case (n)
            1: return (d == 'hF0) ? 8 : (hit(a, d, 'h5555, 'hAA) ? 0 : 1);
            2: return hit(a, d, 'h2AAA, 'h55) ? 0 : 1;
            3: begin
                if ((a & 'h7FFF) != 'h5555) return 1;
                if (d == 'hA0 || d == 'h80) return 0;
                if (d == 'h90) return 7;
                if (d == 'hF0) return 8;
                return 1;
            end
            4: if (qd[2] == 'hA0) return 2;
               else return hit(a, d, 'h5555, 'hAA) ? 0 : 1;
            5: return hit(a, d, 'h2AAA, 'h55) ? 0 : 1;
            6: begin
                if (hit(a, d, 'h5555, 'h10)) return 3;
                if (d == 'h50) return 4;
                if (hit(a, d, 'h5555, 'h70)) return 0;
                return 1;
            end
            default: begin
                if (a == 'h1FFFF) return 5;
                if (a == 0) return 6;
                return 1;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        {e_prog, e_chip, e_page, e_top, e_bot, e_in, e_out} = '0;
        if (!rst_n) begin
            qa.delete(); qd.delete(); e_id = 0;
        end else if (wr_valid && !busy) begin
            int r;
            qa.push_back(int'(wr_addr));
            qd.push_back(int'(wr_data));
            r = classify();
            case (r)
                1: e_id = 0;
                2: begin e_prog = 1; e_paddr = wr_addr; e_pdata = wr_data; end
                3: e_chip = 1;
                4: begin e_page = 1; e_page_n = wr_addr >> 12; end
                5: e_top = 1;
                6: e_bot = 1;
                7: begin e_in = 1; e_id = 1; end
                8: begin e_out = 1; e_id = 0; end
                default: ;
            endcase
            if (r != 0) begin qa.delete(); qd.delete(); end
        end
    end

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    // compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("prog_req", prog_req, e_prog);
            chk("chip_erase_req", chip_erase_req, e_chip);
            chk("page_erase_req", page_erase_req, e_page);
            chk("lock_top_req", lock_top_req, e_top);
            chk("lock_bot_req", lock_bot_req, e_bot);
            chk("id_enter_req", id_enter_req, e_in);
            chk("id_exit_req", id_exit_req, e_out);
            chk("id_mode", id_mode, e_id);
            if (e_prog) begin
                chk("prog_addr", prog_addr, e_paddr);
                chk("prog_data", prog_data, e_pdata);
            end
            if (e_page) chk("page_num", page_num, e_page_n);
        end
    end

    task automatic wr(int a, int d, bit b = 0);
        @(negedge clk);
        wr_valid = 1; wr_addr = a[16:0]; wr_data = d[7:0]; busy = b;
        @(negedge clk);
        wr_valid = 0; busy = 0;
    endtask

    task automatic unlock();
        wr('h5555, 'hAA);
        wr('h2AAA, 'h55);
    endtask

    task automatic ers_prefix();
        unlock();
        wr('h5555, 'h80);
        unlock();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs during and after reset
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        unlock(); wr('h5555, 'hA0); wr('h0_1234, 'h5A);
        cur_req = "R11";
        wr('h1D555, 'hAA); wr('h0AAAA, 'h55); wr('h15555, 'hA0); wr('h1_FFFE, 'hC3);
        cur_req = "R3";
        ers_prefix(); wr('h5555, 'h10);
        cur_req = "R4";
        ers_prefix(); wr('h1A123, 'h50);
        ers_prefix(); wr('h00FFF, 'h50);
        cur_req = "R5";
        ers_prefix(); wr('h5555, 'h70); wr('h1FFFF, 'h00);
        ers_prefix(); wr('h5555, 'h70); wr('h00000, 'h3C);
        ers_prefix(); wr('h5555, 'h70); wr('h00100, 'h00);
        cur_req = "R6";
        unlock(); wr('h5555, 'h90);
        cur_req = "R7";
        unlock(); wr('h5555, 'hF0);
        unlock(); wr('h5555, 'h90);
        wr('h0ABCD, 'hF0);
        wr('h0ABCD, 'hF0);
        cur_req = "R8";
        wr('h5555, 'hAA); wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'hA0);
        wr('h0100, 'h12);
        unlock(); wr('h5555, 'h90);
        wr('h0300, 'h12);
        unlock(); wr('h4444, 'hA0); wr('h0200, 'h77);
        cur_req = "R9";
        wr('h5555, 'hAA, 1); wr('h2AAA, 'h55, 1); wr('h5555, 'hA0, 1); wr('h0050, 'h11, 1);
        unlock(); wr('h5555, 'hA0, 1); wr('h5555, 'hA0); wr('h0777, 'h66);
        unlock(); wr('h5555, 'h90);
        wr('h1234, 'h00, 1);
        cur_req = "R10";
        unlock(); wr('h5555, 'hA0); wr('h0FFFF, 'hFF);
        unlock(); wr('h5555, 'hA0); wr('h5555, 'hAA);
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule